// File: doc/BRIEF.md
# Serial EEPROM Boot Sequencer

After reset this block decides where the device takes its configuration from. A select pin, sampled once in the first cycle after reset, either starts an automatic boot from a serial EEPROM or parks the block in an idle state that leaves configuration to an external host. In EEPROM mode the block becomes an SPI master. It issues a single continuous read that starts just past the fixed manufacturer header. It then parses the incoming byte stream as a series of configuration records.

Each record is one command byte followed by a number of 24-bit data words, and each word travels as three bytes, most significant first. The number of words is fixed per command code by an internal table. For the two variable-length codes, the first word gives the count of words that follow it. Commands go to a downstream command interpreter as a one-cycle strobe. The block holds each command back while the interpreter reports busy. The data words follow as strobes of their own.

The sequence finishes when the filter-start command has been handed over or the last image byte has been consumed, and a done flag is then raised. An unrecognised command code raises an error flag instead. In both cases the chip select is released.

Top module: `eeprom_boot_seq`

## Requirements
- R1: The boot-select input is sampled once, in the first cycle after reset is released. A 1 starts the EEPROM boot. A 0 raises host_idle, keeps spi_cs_n high and produces no strobes. Later changes of boot-select have no effect.
- R2: The read transaction drives spi_cs_n low and sends the opcode 0x03 and then the 16-bit start address 0x0010, both MSB first on spi_mosi. The interface uses SPI mode 0: spi_sck idles low, spi_mosi changes only after a falling spi_sck edge, and spi_miso is sampled on the rising edge. One spi_sck period lasts 2*CLK_DIV clock cycles.
- R3: spi_cs_n falls exactly once per boot and stays low until the sequence ends. Bytes are consumed from consecutive addresses starting at 0x0010, so header bytes 0x0000-0x000F are never interpreted.
- R4: A record is one command byte followed by its data words. Each word is three bytes, and the first byte supplies word bits 23:16.
- R5: The word counts per command code are: 0x00 → 0, 0x01 → 2, 0x03 → 5, 0x04 → 1, 0x07 → 1, 0x08 → 0, 0x09 → 0. For the variable-length codes 0x02 and 0x06, the first word is delivered and its bits 15:0 give the number of words that follow it.
- R6: Each command is presented as a one-cycle cmd_valid with its code on cmd_code. Each data word is presented as a one-cycle word_valid with its value on word_data, in stream order. The two strobes never coincide.
- R7: cmd_valid is never raised in a cycle whose preceding clock edge saw interp_busy high. A pending command waits until busy is low.
- R8: After command 0x08 has been delivered, done rises, spi_cs_n returns high and no further strobes occur.
- R9: Once the byte at address LAST_ADDR has been consumed, the sequence ends with done high and spi_cs_n high, even without a start command.
- R10: Any code outside the table in R5 sets error. No cmd_valid is given for that code, spi_cs_n returns high and done stays low.
- R11: During reset, spi_cs_n is 1, spi_sck is 0, and cmd_valid, word_valid, done, error and host_idle are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_sel | input | 1 | Configuration source select: 1 = EEPROM, 0 = host |
| spi_sck | output | 1 | SPI serial clock to the EEPROM |
| spi_cs_n | output | 1 | Active-low EEPROM chip select |
| spi_mosi | output | 1 | Serial opcode and address to the EEPROM |
| spi_miso | input | 1 | Serial read data from the EEPROM |
| interp_busy | input | 1 | Interpreter is still working on the previous command |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_code | output | 8 | Command code that goes with cmd_valid |
| word_valid | output | 1 | One-cycle data word strobe |
| word_data | output | 24 | Data word that goes with word_valid |
| host_idle | output | 1 | Host-configuration mode selected, block idle |
| done | output | 1 | Boot sequence completed |
| error | output | 1 | Unknown command code encountered |

## Verification
A wrong byte index or word counter in the parser shows up at the ports as soon as the next record. The following command code is taken from the wrong byte, so the strobe list diverges at once and usually ends early in error. A wrong address tracker shows up as done arriving too early or too late against the last image byte. A fault in the serial engine corrupts the captured opcode and address, or the first command, within the first 32 serial clocks. A broken busy gate produces a command strobe inside the interpreter's busy window at the first command that follows a command.

// File: rtl/bootseq_pkg.sv
package bootseq_pkg;

  localparam logic [7:0] OP_READ     = 8'h03;

  localparam logic [7:0] CMD_NOP     = 8'h00;
  localparam logic [7:0] CMD_REG_WR  = 8'h01;
  localparam logic [7:0] CMD_FIR     = 8'h02;
  localparam logic [7:0] CMD_IIR     = 8'h03;
  localparam logic [7:0] CMD_ROMCOEF = 8'h04;
  localparam logic [7:0] CMD_TBS     = 8'h06;
  localparam logic [7:0] CMD_ROMTBS  = 8'h07;
  localparam logic [7:0] CMD_START   = 8'h08;
  localparam logic [7:0] CMD_STOP    = 8'h09;

  typedef struct packed {
    logic       known;
    logic       var_len;
    logic       ends;
    logic [3:0] nwords;
  } cmd_info_t;

  typedef enum logic [1:0] {ENG_IDLE, ENG_SEND, ENG_READY, ENG_RECV} eng_state_e;

  typedef enum logic [2:0] {
    PS_SAMPLE, PS_HOST, PS_CMD, PS_ISSUE, PS_WORD, PS_DONE, PS_ERR
  } psr_state_e;

  function automatic cmd_info_t cmd_lookup(input logic [7:0] code);
    cmd_info_t i;
    i = '{known: 1'b1, var_len: 1'b0, ends: 1'b0, nwords: 4'd0};
    case (code)
      CMD_NOP:     i.nwords = 4'd0;
      CMD_REG_WR:  i.nwords = 4'd2;
      CMD_FIR:     i.var_len = 1'b1;
      CMD_IIR:     i.nwords = 4'd5;
      CMD_ROMCOEF: i.nwords = 4'd1;
      CMD_TBS:     i.var_len = 1'b1;
      CMD_ROMTBS:  i.nwords = 4'd1;
      CMD_START:   i.ends = 1'b1;
      CMD_STOP:    i.nwords = 4'd0;
      default:     i.known = 1'b0;
    endcase
    return i;
  endfunction

endpackage

// File: rtl/bootseq_spi_engine.sv
module bootseq_spi_engine
  import bootseq_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4,
  parameter int unsigned ADDR_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              stop_i,
  input  logic              byte_req_i,
  output logic              byte_valid_o,
  output logic [7:0]        byte_o,
  output logic              sck_o,
  output logic              cs_n_o,
  output logic              mosi_o,
  input  logic              miso_i
);

  localparam int unsigned HDR_BITS = 8 + ADDR_W;
  localparam int unsigned CNT_W    = $clog2(HDR_BITS + 1);
  localparam int unsigned DIV_W    = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  eng_state_e          st_q, st_d;
  logic [DIV_W-1:0]    div_q, div_d;
  logic [CNT_W-1:0]    bit_q, bit_d;
  logic [HDR_BITS-1:0] tx_q, tx_d;
  logic [7:0]          rx_q, rx_d;
  logic                sck_q, sck_d, cs_n_q, cs_n_d, mosi_q, mosi_d, bv_q, bv_d;
  logic                tick;

  assign tick = (div_q == DIV_W'(CLK_DIV - 1));

  always_comb begin
    st_d   = st_q;
    div_d  = div_q;
    bit_d  = bit_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    sck_d  = sck_q;
    cs_n_d = cs_n_q;
    mosi_d = mosi_q;
    bv_d   = 1'b0;
    case (st_q)
      ENG_IDLE: begin
        if (start_i) begin
          st_d   = ENG_SEND;
          cs_n_d = 1'b0;
          tx_d   = {OP_READ, start_addr_i};
          mosi_d = OP_READ[7];
          bit_d  = CNT_W'(HDR_BITS);
          div_d  = '0;
          sck_d  = 1'b0;
        end
      end
      ENG_SEND: begin
        div_d = tick ? '0 : div_q + 1'b1;
        if (tick) begin
          if (!sck_q) begin
            sck_d = 1'b1;
          end else begin
            sck_d  = 1'b0;
            tx_d   = tx_q << 1;
            mosi_d = tx_q[HDR_BITS-2];
            bit_d  = bit_q - 1'b1;
            if (bit_q == CNT_W'(1)) st_d = ENG_READY;
          end
        end
      end
      ENG_READY: begin
        if (byte_req_i) begin
          st_d  = ENG_RECV;
          bit_d = CNT_W'(8);
          div_d = '0;
        end
      end
      ENG_RECV: begin
        div_d = tick ? '0 : div_q + 1'b1;
        if (tick) begin
          if (!sck_q) begin
            sck_d = 1'b1;
            rx_d  = {rx_q[6:0], miso_i};
          end else begin
            sck_d = 1'b0;
            bit_d = bit_q - 1'b1;
            if (bit_q == CNT_W'(1)) begin
              st_d = ENG_READY;
              bv_d = 1'b1;
            end
          end
        end
      end
      default: st_d = ENG_IDLE;
    endcase
    if (stop_i && (st_q != ENG_IDLE)) begin
      st_d   = ENG_IDLE;
      cs_n_d = 1'b1;
      sck_d  = 1'b0;
      bv_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ENG_IDLE;
      div_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      sck_q  <= 1'b0;
      cs_n_q <= 1'b1;
      mosi_q <= 1'b0;
      bv_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      div_q  <= div_d;
      bit_q  <= bit_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      sck_q  <= sck_d;
      cs_n_q <= cs_n_d;
      mosi_q <= mosi_d;
      bv_q   <= bv_d;
    end
  end

  assign byte_valid_o = bv_q;
  assign byte_o       = rx_q;
  assign sck_o        = sck_q;
  assign cs_n_o       = cs_n_q;
  assign mosi_o       = mosi_q;

  // R2: serial clock rests low whenever the device is deselected
  a_r2_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sck_o);

  // R2: output data moves only on a falling clock or at select
  a_r2_mosi_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi_o) |-> ($fell(sck_o) || $fell(cs_n_o)));

  // R3: a byte is only reported while the device is selected
  a_r3_byte_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o |-> !cs_n_o);

endmodule

// File: rtl/bootseq_record_fsm.sv
module bootseq_record_fsm
  import bootseq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned START_ADDR = 'h0010,
  parameter int unsigned LAST_ADDR  = 'h1FFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        boot_sel_i,
  input  logic        interp_busy_i,
  output logic        eng_start_o,
  output logic        eng_stop_o,
  output logic        byte_req_o,
  input  logic        byte_valid_i,
  input  logic [7:0]  byte_i,
  output logic        cmd_valid_o,
  output logic [7:0]  cmd_code_o,
  output logic        word_valid_o,
  output logic [23:0] word_o,
  output logic        host_idle_o,
  output logic        done_o,
  output logic        error_o
);

  psr_state_e        st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0]        code_q, code_d;
  logic [15:0]       left_q, left_d;
  logic              varf_q, varf_d, eoi_q, eoi_d;
  logic [1:0]        bidx_q, bidx_d;
  logic [15:0]       hold_q, hold_d;
  logic              cv_q, cv_d, wv_q, wv_d, host_q, host_d, done_q, done_d;
  logic              err_q, err_d, start_q, start_d;
  logic [7:0]        cc_q, cc_d;
  logic [23:0]       wd_q, wd_d;
  logic              at_last;
  cmd_info_t         rx_info, cur_info;
  logic [23:0]       full_word;
  logic [15:0]       remain;

  assign at_last   = (addr_q == ADDR_W'(LAST_ADDR));
  assign rx_info   = cmd_lookup(byte_i);
  assign cur_info  = cmd_lookup(code_q);
  assign full_word = {hold_q, byte_i};
  assign remain    = varf_q ? full_word[15:0] : (left_q - 16'd1);

  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    code_d  = code_q;
    left_d  = left_q;
    varf_d  = varf_q;
    eoi_d   = eoi_q;
    bidx_d  = bidx_q;
    hold_d  = hold_q;
    cv_d    = 1'b0;
    wv_d    = 1'b0;
    cc_d    = cc_q;
    wd_d    = wd_q;
    host_d  = host_q;
    done_d  = done_q;
    err_d   = err_q;
    start_d = 1'b0;
    case (st_q)
      PS_SAMPLE: begin
        if (boot_sel_i) begin
          start_d = 1'b1;
          st_d    = PS_CMD;
        end else begin
          host_d = 1'b1;
          st_d   = PS_HOST;
        end
      end
      PS_CMD: begin
        if (byte_valid_i) begin
          addr_d = addr_q + 1'b1;
          code_d = byte_i;
          eoi_d  = at_last;
          if (!rx_info.known) begin
            st_d  = PS_ERR;
            err_d = 1'b1;
          end else begin
            st_d = PS_ISSUE;
          end
        end
      end
      PS_ISSUE: begin
        if (!interp_busy_i) begin
          cv_d   = 1'b1;
          cc_d   = code_q;
          bidx_d = 2'd0;
          if (cur_info.ends || eoi_q) begin
            st_d   = PS_DONE;
            done_d = 1'b1;
          end else if (cur_info.var_len) begin
            varf_d = 1'b1;
            left_d = 16'd1;
            st_d   = PS_WORD;
          end else if (cur_info.nwords == 4'd0) begin
            st_d = PS_CMD;
          end else begin
            varf_d = 1'b0;
            left_d = 16'(cur_info.nwords);
            st_d   = PS_WORD;
          end
        end
      end
      PS_WORD: begin
        if (byte_valid_i) begin
          addr_d = addr_q + 1'b1;
          hold_d = {hold_q[7:0], byte_i};
          if (bidx_q == 2'd2) begin
            bidx_d = 2'd0;
            wv_d   = 1'b1;
            wd_d   = full_word;
            varf_d = 1'b0;
            left_d = remain;
            if (remain == 16'd0) st_d = PS_CMD;
          end else begin
            bidx_d = bidx_q + 1'b1;
          end
          if (at_last) begin
            st_d   = PS_DONE;
            done_d = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PS_SAMPLE;
      addr_q  <= ADDR_W'(START_ADDR);
      code_q  <= '0;
      left_q  <= '0;
      varf_q  <= 1'b0;
      eoi_q   <= 1'b0;
      bidx_q  <= '0;
      hold_q  <= '0;
      cv_q    <= 1'b0;
      wv_q    <= 1'b0;
      cc_q    <= '0;
      wd_q    <= '0;
      host_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      addr_q  <= addr_d;
      code_q  <= code_d;
      left_q  <= left_d;
      varf_q  <= varf_d;
      eoi_q   <= eoi_d;
      bidx_q  <= bidx_d;
      hold_q  <= hold_d;
      cv_q    <= cv_d;
      wv_q    <= wv_d;
      cc_q    <= cc_d;
      wd_q    <= wd_d;
      host_q  <= host_d;
      done_q  <= done_d;
      err_q   <= err_d;
      start_q <= start_d;
    end
  end

  assign eng_start_o  = start_q;
  assign eng_stop_o   = (st_q == PS_DONE) || (st_q == PS_ERR);
  assign byte_req_o   = ((st_q == PS_CMD) || (st_q == PS_WORD)) && !byte_valid_i;
  assign cmd_valid_o  = cv_q;
  assign cmd_code_o   = cc_q;
  assign word_valid_o = wv_q;
  assign word_o       = wd_q;
  assign host_idle_o  = host_q;
  assign done_o       = done_q;
  assign error_o      = err_q;

  // R7: no command strobe after an edge that saw the interpreter busy
  a_r7_no_cmd_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> !$past(interp_busy_i));

  // R6: command and word strobes are mutually exclusive
  a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid_o && word_valid_o));

  // R8: nothing is delivered once the sequence has finished
  a_r8_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!cmd_valid_o && !word_valid_o && done_o));

  // R10: error and done never coexist
  a_r10_err_not_done: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |-> !done_o);

  // R1: host mode never starts the reader or emits strobes
  a_r1_host_silent: assert property (@(posedge clk) disable iff (!rst_n)
    host_idle_o |-> (!eng_start_o && !cmd_valid_o && !word_valid_o));

endmodule

// File: rtl/eeprom_boot_seq.sv
module eeprom_boot_seq #(
  parameter int unsigned CLK_DIV    = 4,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned START_ADDR = 'h0010,
  parameter int unsigned LAST_ADDR  = 'h1FFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        boot_sel,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso,
  input  logic        interp_busy,
  output logic        cmd_valid,
  output logic [7:0]  cmd_code,
  output logic        word_valid,
  output logic [23:0] word_data,
  output logic        host_idle,
  output logic        done,
  output logic        error
);

  logic       rst_meta, rst_sync;
  logic       eng_start, eng_stop, byte_req, byte_valid;
  logic [7:0] rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  bootseq_spi_engine #(
    .CLK_DIV (CLK_DIV),
    .ADDR_W  (ADDR_W)
  ) eng_i (
    .clk          (clk),
    .rst_n        (rst_sync),
    .start_i      (eng_start),
    .start_addr_i (ADDR_W'(START_ADDR)),
    .stop_i       (eng_stop),
    .byte_req_i   (byte_req),
    .byte_valid_o (byte_valid),
    .byte_o       (rx_byte),
    .sck_o        (spi_sck),
    .cs_n_o       (spi_cs_n),
    .mosi_o       (spi_mosi),
    .miso_i       (spi_miso)
  );

  bootseq_record_fsm #(
    .ADDR_W     (ADDR_W),
    .START_ADDR (START_ADDR),
    .LAST_ADDR  (LAST_ADDR)
  ) psr_i (
    .clk           (clk),
    .rst_n         (rst_sync),
    .boot_sel_i    (boot_sel),
    .interp_busy_i (interp_busy),
    .eng_start_o   (eng_start),
    .eng_stop_o    (eng_stop),
    .byte_req_o    (byte_req),
    .byte_valid_i  (byte_valid),
    .byte_i        (rx_byte),
    .cmd_valid_o   (cmd_valid),
    .cmd_code_o    (cmd_code),
    .word_valid_o  (word_valid),
    .word_o        (word_data),
    .host_idle_o   (host_idle),
    .done_o        (done),
    .error_o       (error)
  );

  // R10: a bad code releases the chip select on the following edge
  a_r10_err_releases_cs: assert property (@(posedge clk) disable iff (!rst_sync)
    error |=> spi_cs_n);

  // R8: completion releases the chip select on the following edge
  a_r8_done_releases_cs: assert property (@(posedge clk) disable iff (!rst_sync)
    done |=> spi_cs_n);

endmodule

// File: tb/eeprom_boot_seq_tb_top.sv
`timescale 1ns/1ps
module eeprom_boot_seq_tb_top;

  localparam int unsigned DIV  = 2;
  localparam int unsigned LAST = 'h00FF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_sel = 1'b0;
  logic        spi_sck, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;
  logic        interp_busy = 1'b0;
  logic        cmd_valid, word_valid, host_idle, done, error;
  logic [7:0]  cmd_code;
  logic [23:0] word_data;

  always #2.5 clk = ~clk;

  eeprom_boot_seq #(.CLK_DIV(DIV), .LAST_ADDR(LAST)) dut_i (
    .clk(clk), .rst_n(rst_n), .boot_sel(boot_sel),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .interp_busy(interp_busy), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .word_valid(word_valid), .word_data(word_data),
    .host_idle(host_idle), .done(done), .error(error));

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- EEPROM model ----------------
  logic [7:0]  rom [0:255];
  logic [23:0] hdr;
  int          bitn = 0;
  int          cs_falls = 0;
  int          cs_rises = 0;

  always @(negedge spi_cs_n) begin bitn = 0; cs_falls++; end
  always @(posedge spi_cs_n) cs_rises++;
  always @(posedge spi_sck) if (spi_cs_n === 1'b0) begin
    if (bitn < 24) hdr = {hdr[22:0], spi_mosi};
    bitn++;
  end
  always @(negedge spi_sck) if (spi_cs_n === 1'b0 && bitn >= 24) begin
    int idx;
    logic [15:0] a;
    idx = bitn - 24;
    a = hdr[15:0] + 16'(idx / 8);
    spi_miso = rom[a[7:0]][7 - (idx % 8)];
  end

  // ---------------- interpreter model and event log ----------------
  int   busy_len = 0;
  int   busy_cnt = 0;
  int   busy_viol = 0;
  int   ev_n = 0;
  bit   ev_kind [0:511];
  int   ev_val  [0:511];
  int   xp_n = 0;
  bit   xp_kind [0:511];
  int   xp_val  [0:511];
  logic sck_prev = 1'b0;
  int   rise_n = 0;
  int   rise_t0 = 0;
  int   rise_gap = 0;

  always @(negedge clk) begin
    cyc++;
    if (cmd_valid === 1'b1 && interp_busy) busy_viol++;
    if (cmd_valid === 1'b1 && ev_n < 512) begin
      ev_kind[ev_n] = 1'b0; ev_val[ev_n] = int'(cmd_code); ev_n++;
    end
    if (word_valid === 1'b1 && ev_n < 512) begin
      ev_kind[ev_n] = 1'b1; ev_val[ev_n] = int'(word_data); ev_n++;
    end
    if (cmd_valid === 1'b1 && busy_len > 0) busy_cnt = busy_len;
    else if (busy_cnt > 0) busy_cnt--;
    interp_busy = (busy_cnt > 0);
    if (spi_sck === 1'b1 && sck_prev === 1'b0) begin
      if (rise_n == 0) rise_t0 = cyc;
      if (rise_n == 1) rise_gap = cyc - rise_t0;
      rise_n++;
    end
    sck_prev = spi_sck;
  end

  initial begin
    wait (cyc >= 190000);
    chk(1'b0, "WATCHDOG", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // ---------------- image construction ----------------
  int wp;
  task automatic clear_image();
    for (int i = 0; i < 256; i++) rom[i] = 8'hFF;
    for (int i = 0; i < 16; i++) rom[i] = 8'h05;   // header: unknown codes, must be skipped
    wp = 'h10;
    xp_n = 0;
  endtask
  task automatic put_cmd(input logic [7:0] c);
    rom[wp] = c; wp++;
    xp_kind[xp_n] = 1'b0; xp_val[xp_n] = int'(c); xp_n++;
  endtask
  task automatic put_word(input logic [23:0] w);
    rom[wp] = w[23:16]; rom[wp+1] = w[15:8]; rom[wp+2] = w[7:0]; wp += 3;
    xp_kind[xp_n] = 1'b1; xp_val[xp_n] = int'(w); xp_n++;
  endtask

  task automatic start_run(input bit sel, input int blen);
    rst_n = 1'b0;
    busy_len = blen; busy_cnt = 0; interp_busy = 1'b0;
    boot_sel = sel;
    repeat (4) @(negedge clk);
    ev_n = 0; cs_falls = 0; cs_rises = 0; rise_n = 0; rise_gap = 0; busy_viol = 0;
    chk(spi_cs_n === 1'b1 && spi_sck === 1'b0, "R11 reset pins", {spi_cs_n, spi_sck}, 2'b10);
    chk({cmd_valid, word_valid, done, error, host_idle} === 5'b0, "R11 reset flags",
        {cmd_valid, word_valid, done, error, host_idle}, 0);
    rst_n = 1'b1;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 60000; i++) begin
      @(negedge clk);
      if (done === 1'b1 || error === 1'b1) break;
    end
    repeat (20) @(negedge clk);
  endtask

  task automatic compare_events(input string tag);
    chk(ev_n == xp_n, {tag, " R6 strobe count"}, ev_n, xp_n);
    for (int i = 0; i < xp_n && i < ev_n; i++)
      chk(ev_kind[i] == xp_kind[i] && ev_val[i] == xp_val[i], {tag, " R4 R5 event"},
          {ev_kind[i], ev_val[i][23:0]}, {xp_kind[i], xp_val[i][23:0]});
  endtask

  task automatic common_frame(input string tag);
    chk(hdr === 24'h030010, {tag, " R2 opcode and address"}, hdr, 24'h030010);
    chk(rise_gap == 2 * DIV, {tag, " R2 sck period"}, rise_gap, 2 * DIV);
    chk(cs_falls == 1 && cs_rises == 1, {tag, " R3 single frame"}, cs_falls * 16 + cs_rises, 17);
    chk(spi_cs_n === 1'b1 && spi_sck === 1'b0, {tag, " R8 R9 R10 released"}, {spi_cs_n, spi_sck}, 2'b10);
    chk(busy_viol == 0, {tag, " R7 busy gate"}, busy_viol, 0);
  endtask

  initial begin
    // ---------- host mode ----------
    clear_image();
    start_run(1'b0, 0);
    repeat (200) @(negedge clk);
    chk(host_idle === 1'b1, "R1 host idle", host_idle, 1);
    boot_sel = 1'b1;                               // change after sampling: ignored
    repeat (300) @(negedge clk);
    chk(host_idle === 1'b1 && spi_cs_n === 1'b1 && cs_falls == 0, "R1 late select ignored",
        {host_idle, spi_cs_n, 8'(cs_falls)}, 10'h300);
    chk(ev_n == 0 && done === 1'b0 && error === 1'b0, "R1 no strobes in host mode", ev_n, 0);

    // ---------- image A: every command code, long busy ----------
    clear_image();
    put_cmd(8'h00);
    put_cmd(8'h01); put_word(24'h123456); put_word(24'hABCDEF);
    put_cmd(8'h06); put_word(24'hFF0003);
    for (int k = 1; k <= 3; k++) put_word(24'(k * 24'h111111));
    put_cmd(8'h03);
    for (int k = 0; k < 5; k++) put_word(24'h400000 + 24'(k * 24'h010101));
    put_cmd(8'h09);
    put_cmd(8'h04); put_word(24'h00000A);
    put_cmd(8'h07); put_word(24'h5A5A5A);
    put_cmd(8'h02); put_word(24'h770000);        // variable length with zero followers
    put_cmd(8'h08);                               // start: ends sequence, 0xFF bytes follow
    start_run(1'b1, 100);
    wait_end();
    compare_events("A");
    common_frame("A");
    chk(done === 1'b1 && error === 1'b0, "A R8 done after start", {done, error}, 2'b10);
    begin
      int n0;
      n0 = ev_n;
      repeat (200) @(negedge clk);
      chk(ev_n == n0 && spi_cs_n === 1'b1, "A R8 quiet after done", ev_n, n0);
    end

    // ---------- image B: unknown code ----------
    clear_image();
    put_cmd(8'h00);
    put_cmd(8'h01); put_word(24'h000102); put_word(24'h030405);
    rom[wp] = 8'h05; wp++;
    start_run(1'b1, 3);
    wait_end();
    compare_events("B");
    common_frame("B");
    chk(error === 1'b1 && done === 1'b0, "B R10 error flag", {error, done}, 2'b10);

    // ---------- image C: runs to the last address, never busy ----------
    clear_image();
    for (int k = 0; k < 34; k++) begin
      put_cmd(8'h01);
      put_word(24'(k * 24'h030201));
      put_word(~24'(k * 24'h000F0F));
    end
    put_cmd(8'h00);
    put_cmd(8'h00);                                // this byte sits at LAST
    chk(wp == LAST + 1, "C image fills to last address", wp, LAST + 1);
    start_run(1'b1, 0);
    wait_end();
    compare_events("C");
    common_frame("C");
    chk(done === 1'b1 && error === 1'b0, "C R9 done at last address", {done, error}, 2'b10);

    // ---------- image D: last address reached mid-record ----------
    clear_image();
    for (int k = 0; k < 34; k++) begin
      put_cmd(8'h01); put_word(24'(k)); put_word(24'(k + 100));
    end
    put_cmd(8'h04);
    rom[wp] = 8'h12; wp++;                         // partial word cut off at LAST
    start_run(1'b1, 5);
    wait_end();
    compare_events("D");
    chk(done === 1'b1 && error === 1'b0 && spi_cs_n === 1'b1, "D R9 ends mid-record",
        {done, error, spi_cs_n}, 3'b101);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule